// File: doc/BRIEF.md
# Compact Floating-Point Adder-Subtractor

This block adds or subtracts two packed 23-bit floating-point words. Each word has a 6-bit exponent, a sign bit and a 16-bit fraction that sits below an implied leading one. The block belongs with a multiplier that uses the same word layout. An operand pair enters on a valid strobe, together with a select input that chooses sum or difference. A packed result leaves on its own valid strobe a fixed number of cycles later. A new pair can enter on every clock.

Inside, the two operands are ordered by magnitude. The smaller significand is shifted right by the exponent difference. The two significands are then added or subtracted, depending on the effective signs. A leading-one search finds how far the result must move to put its top one back at the implied position, and the larger operand's exponent is corrected by that amount. Bits shifted out are dropped, so rounding is truncation. The datapath has no denormals and no exception flags.

Top module: `cfloat_addsub`

## Requirements
- R1: A word is laid out as exponent in bits [22:17], sign in bit 16 (1 = negative) and fraction in bits [15:0]. The value is (1.fraction) times two to the power of the exponent minus a fixed bias. An exponent of 0 means zero, whatever the sign and fraction bits hold.
- R2: With opSub = 0 and equal signs, the result is the sum of the two magnitudes. The larger operand's exponent is kept when the sum needs no renormalization, and the result carries the common sign.
- R3: With opSub = 1, the result equals the addition result with the sign bit of opB inverted.
- R4: When the effective signs differ, the smaller magnitude is subtracted from the larger. The result takes the sign of the larger-magnitude operand, whichever input port it arrived on.
- R5: A carry out of the significand sum (a sum of 2.0 or more) shifts the significand right by one and raises the exponent by one.
- R6: A result whose significand is exactly zero is output as the all-zero word.
- R7: A zero operand passes the other operand through unchanged. The sign of opB is inverted when opSub = 1.
- R8: An exponent difference of 17 or more returns the larger operand unchanged. A difference of 16 still adds a one into the least significant fraction bit.
- R9: After cancellation, the result is renormalized so that its leading one sits at the implied position. The exponent becomes the larger exponent minus the number of leading zeros of the 18-bit significand sum, plus one.
- R10: A result exponent below 1 gives the all-zero word. A result exponent above 63 is clamped to 63 and the fraction is kept.
- R11: After reset, outValid is 0 and result is all zeros. A pair sampled with inValid at clock edge k gives outValid = 1 and its result after edge k+3, and not before. Pairs on consecutive edges give results on consecutive cycles.
- R12: Significand bits shifted out, either during alignment or during the carry shift, are dropped without rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand pair and opSub are valid this cycle |
| opA | input | 23 | First operand, packed word |
| opB | input | 23 | Second operand, packed word |
| opSub | input | 1 | 0 = opA + opB, 1 = opA - opB |
| outValid | output | 1 | result holds a new value |
| result | output | 23 | Packed sum or difference |

## Verification
The bench builds the block with its default widths, a 6-bit exponent and a 16-bit fraction. With these widths the shift boundary between exponent differences of 16 and 17 can be reached with ordinary mid-range exponents. Values near 1 reach the underflow limit at exponent 1, and two operands at exponent 63 reach the overflow clamp. The 16-bit fraction lets a single least significant bit show the truncation in alignment and in the carry shift, as well as the deepest renormalization, a 16-place left shift.

// File: rtl/cfloat_addsub_pkg.sv
package cfloat_addsub_pkg;
  localparam int DEF_EXP_W = 6;
  localparam int DEF_MAN_W = 16;

  // load strobes issued by the control to each pipeline stage
  typedef struct packed {
    logic ldOrder;
    logic ldSum;
    logic ldNorm;
    logic ldOut;
  } stageStrobe_t;
endpackage

// File: rtl/cfloat_addsub_ctrl.sv
module cfloat_addsub_ctrl
  import cfloat_addsub_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);
  localparam int STAGES = 4;

  logic [STAGES-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) vPipe[0] <= 1'b0;
    else     vPipe[0] <= inValid;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_vstage
    always_ff @(posedge clk) begin
      if (rst) vPipe[i] <= 1'b0;
      else     vPipe[i] <= vPipe[i-1];
    end
  end

  assign strobe.ldOrder = inValid;
  assign strobe.ldSum   = vPipe[0];
  assign strobe.ldNorm  = vPipe[1];
  assign strobe.ldOut   = vPipe[2];
  assign outValid       = vPipe[STAGES-1];

  // R11: an accepted pair shows as outValid four samples later
  p_latency_r11: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##4 outValid);
endmodule

// File: rtl/cfloat_addsub_dp.sv
module cfloat_addsub_dp
  import cfloat_addsub_pkg::*;
#(
  parameter int EXP_W = DEF_EXP_W,
  parameter int MAN_W = DEF_MAN_W,
  localparam int WORD_W = EXP_W + 1 + MAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  stageStrobe_t      strobe,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              opSub,
  output logic [WORD_W-1:0] result
);
  localparam int SIG_W = MAN_W + 1;
  localparam int SUM_W = MAN_W + 2;
  localparam int KEY_W = EXP_W + MAN_W;
  localparam int POS_W = $clog2(SUM_W);
  localparam int XE_W  = EXP_W + 2;
  localparam logic [EXP_W-1:0] EXP_TOP = '1;

  // ---------------- stage 1: unpack, order by magnitude ----------------
  logic [EXP_W-1:0] aExp, bExp;
  logic [MAN_W-1:0] aMan, bMan;
  logic             aSign, bSignEff, aZero, bZero, swapOps;
  logic [KEY_W-1:0] aKey, bKey;
  logic [SIG_W-1:0] aSig, bSig;

  assign aExp     = opA[WORD_W-1 -: EXP_W];
  assign bExp     = opB[WORD_W-1 -: EXP_W];
  assign aSign    = opA[MAN_W];
  assign bSignEff = opB[MAN_W] ^ opSub;
  assign aMan     = opA[MAN_W-1:0];
  assign bMan     = opB[MAN_W-1:0];
  assign aZero    = (aExp == '0);
  assign bZero    = (bExp == '0);
  assign aKey     = aZero ? '0 : {aExp, aMan};
  assign bKey     = bZero ? '0 : {bExp, bMan};
  assign aSig     = aZero ? '0 : {1'b1, aMan};
  assign bSig     = bZero ? '0 : {1'b1, bMan};
  assign swapOps  = (aKey < bKey);

  logic [EXP_W-1:0] s1BigExp, s1Diff;
  logic [SIG_W-1:0] s1BigSig, s1SmallSig;
  logic             s1BigSign, s1EffSub;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1BigExp   <= '0;
      s1Diff     <= '0;
      s1BigSig   <= '0;
      s1SmallSig <= '0;
      s1BigSign  <= 1'b0;
      s1EffSub   <= 1'b0;
    end else if (strobe.ldOrder) begin
      s1BigExp   <= swapOps ? bExp : aExp;
      s1Diff     <= swapOps ? (bExp - aExp) : (aExp - bExp);
      s1BigSig   <= swapOps ? bSig : aSig;
      s1SmallSig <= swapOps ? aSig : bSig;
      s1BigSign  <= swapOps ? bSignEff : aSign;
      s1EffSub   <= aSign ^ bSignEff;
    end
  end

  // ---------------- stage 2: align and combine ----------------
  logic [SIG_W-1:0] shiftedSig;
  logic [SUM_W-1:0] bigExt, smallExt, sumComb;

  assign shiftedSig = (int'(s1Diff) >= SIG_W) ? '0 : (s1SmallSig >> s1Diff);
  assign bigExt     = {1'b0, s1BigSig};
  assign smallExt   = {1'b0, shiftedSig};
  assign sumComb    = s1EffSub ? (bigExt - smallExt) : (bigExt + smallExt);

  logic [SUM_W-1:0] s2Sum;
  logic [EXP_W-1:0] s2BigExp;
  logic             s2Sign;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2Sum    <= '0;
      s2BigExp <= '0;
      s2Sign   <= 1'b0;
    end else if (strobe.ldSum) begin
      s2Sum    <= sumComb;
      s2BigExp <= s1BigExp;
      s2Sign   <= s1BigSign;
    end
  end

  // R4: the aligned smaller significand never exceeds the larger one
  p_order_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.ldSum && s1EffSub) |-> (shiftedSig <= s1BigSig));

  // ---------------- stage 3: leading one and renormalize ----------------
  logic [POS_W-1:0] msbPos;
  logic             sumZero;

  always_comb begin
    msbPos  = '0;
    sumZero = 1'b1;
    for (int i = 0; i < SUM_W; i++) begin
      if (s2Sum[i]) begin
        msbPos  = POS_W'(i);
        sumZero = 1'b0;
      end
    end
  end

  logic [SUM_W-1:0] shiftedUp;
  logic [SIG_W-1:0] normSig;
  logic signed [XE_W-1:0] expComb;

  assign shiftedUp = s2Sum << (POS_W'(SIG_W-1) - msbPos);

  always_comb begin
    if (msbPos == POS_W'(SUM_W-1)) normSig = s2Sum[SUM_W-1:1];
    else                           normSig = shiftedUp[SIG_W-1:0];
  end

  assign expComb = XE_W'(s2BigExp) + XE_W'(msbPos) - XE_W'(SIG_W-1);

  // R9: a nonzero sum always lands with its leading one at the implied bit
  p_norm_hidden_r9: assert property (@(posedge clk) disable iff (rst)
    (strobe.ldNorm && !sumZero) |-> normSig[SIG_W-1]);

  logic [MAN_W-1:0]       s3Man;
  logic signed [XE_W-1:0] s3Exp;
  logic                   s3Sign, s3Zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      s3Man  <= '0;
      s3Exp  <= '0;
      s3Sign <= 1'b0;
      s3Zero <= 1'b1;
    end else if (strobe.ldNorm) begin
      s3Man  <= normSig[MAN_W-1:0];
      s3Exp  <= expComb;
      s3Sign <= s2Sign;
      s3Zero <= sumZero;
    end
  end

  // ---------------- stage 4: range limit and pack ----------------
  logic [WORD_W-1:0] packed_w;

  always_comb begin
    if (s3Zero || (s3Exp < $signed(XE_W'(1))))
      packed_w = '0;
    else if (s3Exp > $signed(XE_W'(EXP_TOP)))
      packed_w = {EXP_TOP, s3Sign, s3Man};
    else
      packed_w = {s3Exp[EXP_W-1:0], s3Sign, s3Man};
  end

  always_ff @(posedge clk) begin
    if (rst)               result <= '0;
    else if (strobe.ldOut) result <= packed_w;
  end

  // R6: a zero exponent at the output only ever comes as the all-zero word
  p_zero_word_r6: assert property (@(posedge clk) disable iff (rst)
    (result[WORD_W-1 -: EXP_W] == '0) |-> (result == '0));
endmodule

// File: rtl/cfloat_addsub.sv
module cfloat_addsub
  import cfloat_addsub_pkg::*;
#(
  parameter int EXP_W = DEF_EXP_W,
  parameter int MAN_W = DEF_MAN_W,
  localparam int WORD_W = EXP_W + 1 + MAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              opSub,
  output logic              outValid,
  output logic [WORD_W-1:0] result
);
  stageStrobe_t strobe;

  cfloat_addsub_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  cfloat_addsub_dp #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .opSub  (opSub),
    .result (result)
  );
endmodule

// File: tb/sim_cfloat_addsub.sv
module sim_cfloat_addsub;
  localparam int NV = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [22:0] opA = '0;
  logic [22:0] opB = '0;
  logic        opSub = 1'b0;
  logic        outValid;
  logic [22:0] result;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfloat_addsub u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .opSub(opSub), .outValid(outValid), .result(result)
  );

  // {tag, opA {exp,sign,frac}, opB {exp,sign,frac}, opSub, expected}
  localparam logic [77:0] VECS [NV] = '{
    {8'd1,  6'd0, 1'b1,16'hFFFF, 6'd25,1'b0,16'h1111, 1'b0, 6'd25,1'b0,16'h1111}, // R1
    {8'd2,  6'd32,1'b0,16'h0000, 6'd31,1'b0,16'h0000, 1'b0, 6'd32,1'b0,16'h8000}, // R2
    {8'd5,  6'd32,1'b0,16'h0000, 6'd32,1'b0,16'h0000, 1'b0, 6'd33,1'b0,16'h0000}, // R5
    {8'd5,  6'd32,1'b0,16'h8000, 6'd32,1'b0,16'h4000, 1'b0, 6'd33,1'b0,16'h6000}, // R5
    {8'd3,  6'd32,1'b0,16'h8000, 6'd32,1'b0,16'h0000, 1'b1, 6'd31,1'b0,16'h0000}, // R3
    {8'd3,  6'd32,1'b1,16'h0000, 6'd33,1'b1,16'h0000, 1'b1, 6'd32,1'b0,16'h0000}, // R3
    {8'd4,  6'd32,1'b0,16'h0000, 6'd33,1'b1,16'h0000, 1'b0, 6'd32,1'b1,16'h0000}, // R4
    {8'd4,  6'd30,1'b0,16'h0000, 6'd32,1'b0,16'h0000, 1'b1, 6'd31,1'b1,16'h8000}, // R4
    {8'd4,  6'd32,1'b1,16'h1000, 6'd32,1'b0,16'h2000, 1'b0, 6'd28,1'b0,16'h0000}, // R4
    {8'd6,  6'd40,1'b0,16'h1234, 6'd40,1'b0,16'h1234, 1'b1, 6'd0, 1'b0,16'h0000}, // R6
    {8'd6,  6'd40,1'b0,16'h1234, 6'd40,1'b1,16'h1234, 1'b0, 6'd0, 1'b0,16'h0000}, // R6
    {8'd6,  6'd32,1'b1,16'h0000, 6'd32,1'b1,16'h0000, 1'b1, 6'd0, 1'b0,16'h0000}, // R6
    {8'd7,  6'd0, 1'b0,16'h0000, 6'd20,1'b1,16'hABCD, 1'b1, 6'd20,1'b0,16'hABCD}, // R7
    {8'd7,  6'd20,1'b1,16'hABCD, 6'd0, 1'b0,16'h0000, 1'b0, 6'd20,1'b1,16'hABCD}, // R7
    {8'd7,  6'd0, 1'b0,16'h0000, 6'd0, 1'b0,16'h0000, 1'b0, 6'd0, 1'b0,16'h0000}, // R7
    {8'd8,  6'd50,1'b0,16'h5555, 6'd33,1'b0,16'hFFFF, 1'b0, 6'd50,1'b0,16'h5555}, // R8
    {8'd8,  6'd33,1'b0,16'hFFFF, 6'd50,1'b0,16'h5555, 1'b1, 6'd50,1'b1,16'h5555}, // R8
    {8'd8,  6'd50,1'b0,16'h0000, 6'd34,1'b0,16'h0000, 1'b0, 6'd50,1'b0,16'h0001}, // R8
    {8'd9,  6'd20,1'b0,16'h0001, 6'd20,1'b0,16'h0000, 1'b1, 6'd4, 1'b0,16'h0000}, // R9
    {8'd10, 6'd63,1'b0,16'h8000, 6'd63,1'b0,16'h8000, 1'b0, 6'd63,1'b0,16'h8000}, // R10
    {8'd10, 6'd1, 1'b0,16'h8000, 6'd1, 1'b0,16'h0000, 1'b1, 6'd0, 1'b0,16'h0000}, // R10
    {8'd10, 6'd10,1'b0,16'h0001, 6'd10,1'b0,16'h0000, 1'b1, 6'd0, 1'b0,16'h0000}, // R10
    {8'd12, 6'd32,1'b0,16'h0000, 6'd32,1'b0,16'h0001, 1'b0, 6'd33,1'b0,16'h0000}, // R12
    {8'd12, 6'd32,1'b0,16'h0000, 6'd31,1'b0,16'h0001, 1'b0, 6'd32,1'b0,16'h8000}  // R12
  };

  task automatic chk(input int tag, input logic [22:0] act, input logic [22:0] expv);
    testsRun++;
    if (act !== expv) begin
      testsFailed++;
      $display("FAIL R%0d: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic [77:0] v);
    inValid = 1'b1;
    opA = v[69:47];
    opB = v[46:24];
    opSub = v[23];
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk(11, {22'd0, outValid}, 23'd0);
    chk(11, result, 23'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(posedge clk);          // sampling edge k
      @(negedge clk);
      inValid = 1'b0;
      @(posedge clk);
      @(posedge clk);          // edge k+2
      @(negedge clk);
      chk(11, {22'd0, outValid}, 23'd0); // R11: not early
      @(posedge clk);          // edge k+3
      @(negedge clk);
      chk(11, {22'd0, outValid}, 23'd1); // R11: on time
      chk(int'(VECS[i][77:70]), result, VECS[i][22:0]);
      @(negedge clk);
      chk(11, {22'd0, outValid}, 23'd0); // R11: single pulse
    end

    // R11: back-to-back pairs, one per cycle
    drive(VECS[2]);
    @(negedge clk);
    drive(VECS[3]);
    @(negedge clk);
    drive(VECS[4]);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    chk(11, {22'd0, outValid}, 23'd1);
    chk(5, result, VECS[2][22:0]);
    @(negedge clk);
    chk(11, {22'd0, outValid}, 23'd1);
    chk(5, result, VECS[3][22:0]);
    @(negedge clk);
    chk(11, {22'd0, outValid}, 23'd1);
    chk(3, result, VECS[4][22:0]);
    @(negedge clk);
    chk(11, {22'd0, outValid}, 23'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R11: watchdog expired, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule